// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This combinational block picks the two operands, A and B, handed to the execute stage of a five-stage in-order pipeline. By default it passes through the values read from the register file when the instruction was decoded. When an older instruction that is still in flight will write a register the consumer reads, it returns that instruction's result instead. Candidate producers sit in three latches: the EX/MEM latch, the MEM/WB latch, and a write-back-end latch that keeps a retired instruction's result for one more cycle.

Inputs are the consumer instruction, the three producer instructions, the three producer results and the two decode-time register values. Outputs are the two selected operands. The ALU, hazard stalls and memories are outside the block.

Top module: `fwd_select`

## Requirements
- R1: Instruction encoding. The opcode is bits [24:22], source field s0 is bits [21:19], field s1 is bits [18:16] and field d2 is bits [2:0]. Opcode values are: add=0, nor=1, load=2, store=3, branch-if-equal=4. Codes 5, 6 and 7 cover jump, halt and no-op.
- R2: A producer holding add or nor writes register d2. A producer holding load writes register s1.
- R3: The EX/MEM latch supplies its ALU result only when it holds add or nor and its destination equals the consumer's source. A load there never supplies a value.
- R4: The MEM/WB latch supplies its write data when it holds add, nor or load and its destination matches.
- R5: The write-back-end latch supplies its data under the same conditions as MEM/WB.
- R6: When several latches match, EX/MEM wins over MEM/WB, and MEM/WB wins over the write-back-end latch.
- R7: For a consumer holding add, nor, store or branch-if-equal, operand A is compared against s0 and operand B against s1, and both can be forwarded.
- R8: For a consumer holding load, only operand A can be forwarded. Operand B always equals the decode-time B value.
- R9: For a consumer holding opcode 5, 6 or 7, both operands equal the decode-time values.
- R10: When no latch matches, each operand equals its decode-time value.
- R11: A producer holding store, branch-if-equal or opcodes 5 to 7 never matches, whatever its fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cons_instr | input | 32 | Instruction in the ID/EX latch (the consumer) |
| exm_instr | input | 32 | Instruction in the EX/MEM latch |
| mwb_instr | input | 32 | Instruction in the MEM/WB latch |
| wbe_instr | input | 32 | Instruction in the write-back-end latch |
| exm_result | input | 32 | ALU result held in EX/MEM |
| mwb_result | input | 32 | Write data held in MEM/WB |
| wbe_result | input | 32 | Write data held in the write-back-end latch |
| dec_a | input | 32 | Operand A read from the register file at decode |
| dec_b | input | 32 | Operand B read from the register file at decode |
| opnd_a | output | 32 | Selected operand A for execute |
| opnd_b | output | 32 | Selected operand B for execute |

## Verification
The assertions assume that all inputs settle together, so that an output is judged against the inputs of the same evaluation. They also assume that opcodes are the 3-bit codes of R1, where every code is legal. The stimulus changes every input once per clock and samples half a period later. It sweeps every combination of consumer opcode and the three producer opcodes. The register fields are drawn from only two values, so destination matches, multi-stage collisions and misses all occur often.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int DATA_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int OP_BITS  = 3,
  parameter int REG_BITS = 3,
  parameter int OP_LSB   = 22,
  parameter int S0_LSB   = 19,
  parameter int S1_LSB   = 16,
  parameter int D2_LSB   = 0
) (
  input  logic [INSTR_W-1:0] cons_instr,
  input  logic [INSTR_W-1:0] exm_instr,
  input  logic [INSTR_W-1:0] mwb_instr,
  input  logic [INSTR_W-1:0] wbe_instr,
  input  logic [DATA_W-1:0]  exm_result,
  input  logic [DATA_W-1:0]  mwb_result,
  input  logic [DATA_W-1:0]  wbe_result,
  input  logic [DATA_W-1:0]  dec_a,
  input  logic [DATA_W-1:0]  dec_b,
  output logic [DATA_W-1:0]  opnd_a,
  output logic [DATA_W-1:0]  opnd_b
);
  localparam logic [OP_BITS-1:0] OP_ADD = OP_BITS'(0);
  localparam logic [OP_BITS-1:0] OP_NOR = OP_BITS'(1);
  localparam logic [OP_BITS-1:0] OP_LD  = OP_BITS'(2);
  localparam logic [OP_BITS-1:0] OP_ST  = OP_BITS'(3);
  localparam logic [OP_BITS-1:0] OP_BEQ = OP_BITS'(4);

  function automatic logic [OP_BITS-1:0] op_of(input logic [INSTR_W-1:0] i);
    return i[OP_LSB +: OP_BITS];
  endfunction

  function automatic logic is_alu(input logic [INSTR_W-1:0] i);
    return op_of(i) == OP_ADD || op_of(i) == OP_NOR;
  endfunction

  function automatic logic [REG_BITS-1:0] dest_of(input logic [INSTR_W-1:0] i);
    return (op_of(i) == OP_LD) ? i[S1_LSB +: REG_BITS] : i[D2_LSB +: REG_BITS];
  endfunction

  logic [OP_BITS-1:0]  cop;
  logic [REG_BITS-1:0] src_a, src_b;
  logic                use_a, use_b;
  logic                exm_wr, mwb_wr, wbe_wr;
  logic [REG_BITS-1:0] exm_dst, mwb_dst, wbe_dst;

  assign cop   = op_of(cons_instr);
  assign src_a = cons_instr[S0_LSB +: REG_BITS];
  assign src_b = cons_instr[S1_LSB +: REG_BITS];
  assign use_a = cop == OP_ADD || cop == OP_NOR || cop == OP_LD || cop == OP_ST || cop == OP_BEQ;
  assign use_b = use_a && cop != OP_LD;

  assign exm_wr = is_alu(exm_instr);
  assign mwb_wr = is_alu(mwb_instr) || op_of(mwb_instr) == OP_LD;
  assign wbe_wr = is_alu(wbe_instr) || op_of(wbe_instr) == OP_LD;

  assign exm_dst = dest_of(exm_instr);
  assign mwb_dst = dest_of(mwb_instr);
  assign wbe_dst = dest_of(wbe_instr);

  always_comb begin
    opnd_a = dec_a;
    if (use_a) begin
      if (exm_wr && exm_dst == src_a)      opnd_a = exm_result;
      else if (mwb_wr && mwb_dst == src_a) opnd_a = mwb_result;
      else if (wbe_wr && wbe_dst == src_a) opnd_a = wbe_result;
    end
  end

  always_comb begin
    opnd_b = dec_b;
    if (use_b) begin
      if (exm_wr && exm_dst == src_b)      opnd_b = exm_result;
      else if (mwb_wr && mwb_dst == src_b) opnd_b = mwb_result;
      else if (wbe_wr && wbe_dst == src_b) opnd_b = wbe_result;
    end
  end
endmodule

module fwd_select_chk #(
  parameter int DATA_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int OP_BITS  = 3,
  parameter int REG_BITS = 3,
  parameter int OP_LSB   = 22,
  parameter int S0_LSB   = 19,
  parameter int S1_LSB   = 16,
  parameter int D2_LSB   = 0
) (
  input logic [INSTR_W-1:0] cons_instr,
  input logic [INSTR_W-1:0] exm_instr,
  input logic [INSTR_W-1:0] mwb_instr,
  input logic [INSTR_W-1:0] wbe_instr,
  input logic [DATA_W-1:0]  exm_result,
  input logic [DATA_W-1:0]  dec_a,
  input logic [DATA_W-1:0]  dec_b,
  input logic [DATA_W-1:0]  opnd_a,
  input logic [DATA_W-1:0]  opnd_b
);
  logic [OP_BITS-1:0] c_op, e_op, m_op, w_op;
  assign c_op = cons_instr[OP_LSB +: OP_BITS];
  assign e_op = exm_instr[OP_LSB +: OP_BITS];
  assign m_op = mwb_instr[OP_LSB +: OP_BITS];
  assign w_op = wbe_instr[OP_LSB +: OP_BITS];

  always_comb begin
    // R3 and R6: an add/nor in EX/MEM that matches A always wins
    if (c_op <= OP_BITS'(4) && e_op <= OP_BITS'(1) &&
        exm_instr[D2_LSB +: REG_BITS] == cons_instr[S0_LSB +: REG_BITS])
      a_r3_exm_first: assert (opnd_a == exm_result);
    // R8: a load consumer never has B replaced
    if (c_op == OP_BITS'(2))
      a_r8_load_b_kept: assert (opnd_b == dec_b);
    // R9: consumers with opcodes 5..7 see decode values only
    if (c_op >= OP_BITS'(5))
      a_r9_no_reader: assert (opnd_a == dec_a && opnd_b == dec_b);
    // R11: producers that write nothing leave both operands alone
    if (e_op >= OP_BITS'(2) && m_op >= OP_BITS'(3) && w_op >= OP_BITS'(3))
      a_r11_no_writer: assert (opnd_a == dec_a && opnd_b == dec_b);
  end
endmodule

bind fwd_select fwd_select_chk #(
  .DATA_W(DATA_W), .INSTR_W(INSTR_W), .OP_BITS(OP_BITS), .REG_BITS(REG_BITS),
  .OP_LSB(OP_LSB), .S0_LSB(S0_LSB), .S1_LSB(S1_LSB), .D2_LSB(D2_LSB)
) u_chk (
  .cons_instr(cons_instr), .exm_instr(exm_instr), .mwb_instr(mwb_instr),
  .wbe_instr(wbe_instr), .exm_result(exm_result), .dec_a(dec_a), .dec_b(dec_b),
  .opnd_a(opnd_a), .opnd_b(opnd_b)
);

// File: tb/test_fwd_select.sv
module test_fwd_select;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] cons_instr, exm_instr, mwb_instr, wbe_instr;
  logic [31:0] exm_result, mwb_result, wbe_result, dec_a, dec_b;
  logic [31:0] opnd_a, opnd_b;

  fwd_select i_fwd_select (
    .cons_instr(cons_instr), .exm_instr(exm_instr), .mwb_instr(mwb_instr),
    .wbe_instr(wbe_instr), .exm_result(exm_result), .mwb_result(mwb_result),
    .wbe_result(wbe_result), .dec_a(dec_a), .dec_b(dec_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // R1 encoding
  function automatic logic [31:0] mk(input int op, input int s0, input int s1, input int d2);
    return (32'(op) << 22) | (32'(s0) << 19) | (32'(s1) << 16) | 32'(d2);
  endfunction

  // Expected value of one operand, written from R2..R11; tag names the deciding rule
  function automatic logic [31:0] expect_op(input int cop, input int src, input bit is_b,
                                            input int eop, input int ed,
                                            input int mop, input int md,
                                            input int wop, input int wd,
                                            input logic [31:0] dflt, output string tag);
    if (cop > 4) begin tag = "R9"; return dflt; end
    if (is_b && cop == 2) begin tag = "R8"; return dflt; end
    if (eop <= 1 && ed == src) begin tag = "R3"; return exm_result; end
    if (mop <= 2 && md == src) begin tag = "R4"; return mwb_result; end
    if (wop <= 2 && wd == src) begin tag = "R5"; return wbe_result; end
    tag = "R10";
    return dflt;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lf = 32'hACE1_2468;
    string t;
    logic [31:0] ea, eb;
    cons_instr = mk(7,0,0,0); exm_instr = mk(7,0,0,0);
    mwb_instr = mk(7,0,0,0); wbe_instr = mk(7,0,0,0);
    exm_result = 32'hE0; mwb_result = 32'hB0; wbe_result = 32'hC0;
    dec_a = 32'hDA; dec_b = 32'hDB;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 idle", opnd_a, 32'hDA);
    check("R10 idle", opnd_b, 32'hDB);

    // Directed: R6 all three match on A, R2 load dest is s1
    @(posedge clk);
    cons_instr = mk(0,3,4,1); exm_instr = mk(1,0,0,3);
    mwb_instr = mk(2,0,3,0); wbe_instr = mk(0,0,0,3);
    @(negedge clk);
    check("R6 exm first", opnd_a, 32'hE0);
    @(posedge clk); exm_instr = mk(2,0,3,3);
    @(negedge clk);
    check("R6 mwb next / R3 load in exm", opnd_a, 32'hB0);
    @(posedge clk); mwb_instr = mk(2,0,5,3);
    @(negedge clk);
    check("R6 wbe last / R2", opnd_a, 32'hC0);
    @(posedge clk); wbe_instr = mk(2,0,4,0);
    @(negedge clk);
    check("R2 load dest s1 / R7 B", opnd_b, 32'hC0);
    check("R10 A miss", opnd_a, 32'hDA);
    @(posedge clk); cons_instr = mk(2,3,4,1);
    @(negedge clk);
    check("R8 load consumer B", opnd_b, 32'hDB);
    @(posedge clk); cons_instr = mk(3,3,4,1); exm_instr = mk(3,0,4,4); mwb_instr = mk(4,4,4,4);
    wbe_instr = mk(6,4,4,4);
    @(negedge clk);
    check("R11 non-writers", opnd_b, 32'hDB);
    check("R11 non-writers", opnd_a, 32'hDA);

    // Sweep: every consumer/producer opcode combination, fields from {1,2}
    for (int c = 0; c < 8; c++)
      for (int e = 0; e < 8; e++)
        for (int m = 0; m < 8; m++)
          for (int w = 0; w < 8; w++)
            for (int p = 0; p < 3; p++) begin
              int f[9];
              lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
              for (int k = 0; k < 9; k++) f[k] = 1 + int'(lf[k*3]);
              @(posedge clk);
              cons_instr = mk(c, f[0], f[1], 0);
              exm_instr  = mk(e, 0, 0, f[2]);
              mwb_instr  = mk(m, 0, f[3], f[4]);
              wbe_instr  = mk(w, 0, f[5], f[6]);
              exm_result = lf ^ 32'h1111_1111;
              mwb_result = lf ^ 32'h2222_2222;
              wbe_result = lf ^ 32'h4444_4444;
              dec_a = lf ^ 32'h8888_8888;
              dec_b = ~lf;
              @(negedge clk);
              ea = expect_op(c, f[0], 1'b0, e, f[2], m, (m == 2) ? f[3] : f[4],
                             w, (w == 2) ? f[5] : f[6], dec_a, t);
              check({t, " sweep A (R7)"}, opnd_a, ea);
              eb = expect_op(c, f[1], 1'b1, e, f[2], m, (m == 2) ? f[3] : f[4],
                             w, (w == 2) ? f[5] : f[6], dec_b, t);
              check({t, " sweep B (R7)"}, opnd_b, eb);
            end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule